// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register Front End

This block is the host-facing register file of a bus-master disk DMA controller with two independent channels. It sits behind a small I/O window of eight bytes per channel. The low dword of each channel's slice holds a control byte and a flag byte. The high dword holds the 32-bit address of the channel's descriptor list. Host accesses arrive as dword-indexed requests with four byte enables. The read answer comes back one cycle later with a valid flag.

Toward the DMA engine the block presents each channel's run and direction bits, its flag byte and its descriptor pointer. It also issues one-cycle begin and halt pulses whenever the host toggles the run bit. The engine drives the busy flag and raises the fault and done flags through one-cycle strobes.

The control and flag byte accept only single-byte accesses. A host that reads them with a wider access sees all ones, and a wider write to them is thrown away. The flag byte combines engine-owned, write-one-to-clear and plain read/write bits.

Top module: `bmdma_regfile`

## Requirements
- R1: While reset is low and after it, until the first access, every control byte, flag byte and pointer reads as zero, `rd_valid` is 0, `rd_data` is 0 and no begin/halt pulse is driven.
- R2: `host_addr` is a dword index: bit 0 selects the control dword (0) or the pointer dword (1), and the upper bits pick the channel. In the control dword, byte lane 0 is the control byte, lane 2 is the flag byte, and lanes 1 and 3 read as 0xFF and ignore writes.
- R3: A read of the control dword with more than one byte enable set returns 0xFF in every enabled lane and 0x00 in the others, and changes nothing.
- R4: A write to the control dword with more than one (or no) byte enable set leaves the control and flag bytes unchanged.
- R5: A single-byte write to the flag byte loads bits 5 and 6 from the data, clears bit 1 and bit 2 where the data bit is 1, leaves bit 0 alone, and keeps bits 3, 4 and 7 at 0.
- R6: Flag bit 0 (busy) is set by `eng_act_set` and cleared by `eng_act_clr` of its channel. Set wins when both arrive together. Host writes never change it.
- R7: `eng_err_set` sets flag bit 1 and `eng_irq_set` sets flag bit 2 in the next cycle. A strobe wins over a host clear in the same cycle.
- R8: The control byte keeps bit 0 (run) and bit 3 (direction). Its other bits read 0. A write that takes run from 0 to 1 gives a one-cycle `start_pulse`, and a write from 1 to 0 gives a one-cycle `stop_pulse`. Both pulses appear in the cycle the new run value is visible.
- R9: The pointer dword is written per byte lane under the byte enables. Its bits 1:0 always read 0.
- R10: A read request gives `rd_valid` high exactly one cycle later, with `rd_data` holding the register values from the request cycle masked to the enabled lanes. With no read answer, `rd_data` is 0.
- R11: An access or strobe aimed at one channel never changes the other channel's registers or pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access valid this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | AW (2) | Dword index: channel and control/pointer select |
| host_be | input | 4 | Byte enables, lane k = bits 8k+7:8k |
| host_wdata | input | 32 | Write data on natural lanes |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 32 | Read answer |
| cmd_run | output | NUM_CH | Run bit per channel |
| cmd_dir | output | NUM_CH | Direction bit per channel |
| start_pulse | output | NUM_CH | One-cycle begin pulse |
| stop_pulse | output | NUM_CH | One-cycle halt pulse |
| status_q | output | 8*NUM_CH | Flag byte per channel |
| desc_ptr | output | 32*NUM_CH | Descriptor pointer per channel |
| eng_act_set | input | NUM_CH | Engine sets busy |
| eng_act_clr | input | NUM_CH | Engine clears busy |
| eng_err_set | input | NUM_CH | Engine raises fault flag |
| eng_irq_set | input | NUM_CH | Engine raises done flag |

## Verification
The bench builds the block with its default of two channels. With two channels the channel-select bit is live, so every access aimed at one channel can be checked against the untouched state of the other. Directed phases cover the lane map, wide reads and writes of the control dword, and the per-bit flag rules. They also cover set-versus-clear collisions and run-bit toggles. A long mixed phase then drives random accesses with single, half and full byte-enable patterns against random engine strobes on both channels.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   localparam int unsigned LANES    = 4;
   localparam int unsigned PTR_W    = 32;
   localparam int unsigned PTR_ZERO = 2;
   // flag byte bit positions
   localparam int unsigned F_BUSY  = 0;
   localparam int unsigned F_FAULT = 1;
   localparam int unsigned F_DONE  = 2;
   localparam int unsigned F_CAPA  = 5;
   localparam int unsigned F_CAPB  = 6;
   // control byte bit positions
   localparam int unsigned C_RUN = 0;
   localparam int unsigned C_DIR = 3;
   // lanes inside the control dword
   localparam logic [1:0] LANE_CTL  = 2'd0;
   localparam logic [1:0] LANE_FLAG = 2'd2;

   function automatic logic one_lane(input logic [LANES-1:0] be);
      return ($countones(be) == 1);
   endfunction

   function automatic logic [1:0] lane_of(input logic [LANES-1:0] be);
      logic [1:0] k;
      k = 2'd0;
      for (int i = 0; i < LANES; i++)
         if (be[i]) k = 2'(i);
      return k;
   endfunction

   function automatic logic [31:0] lane_mask(input logic [LANES-1:0] be);
      logic [31:0] m;
      for (int i = 0; i < LANES; i++)
         m[8*i +: 8] = {8{be[i]}};
      return m;
   endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   localparam int unsigned CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned AW  = (NUM_CH > 1) ? CIW + 1 : 1
) (
   input  logic [AW-1:0]    addr,
   input  logic [LANES-1:0] be,
   input  logic [31:0]      wdata,
   output logic [CIW-1:0]   chan_idx,
   output logic             chan_ok,
   output logic             is_ptr,
   output logic             single,
   output logic [1:0]       lane,
   output logic [7:0]       wbyte
);
   assign is_ptr = addr[0];
   assign single = one_lane(be);
   assign lane   = lane_of(be);
   assign wbyte  = wdata[8*lane +: 8];

   generate
      if (NUM_CH > 1) begin : g_multi
         assign chan_idx = addr[AW-1:1];
         assign chan_ok  = (32'(addr[AW-1:1]) < NUM_CH);
      end else begin : g_single
         assign chan_idx = '0;
         assign chan_ok  = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
   import bmdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic              wr_flag,
   input  logic              wr_ptr,
   input  logic [7:0]        wbyte,
   input  logic [LANES-1:0]  be,
   input  logic [31:0]       wdata,
   input  logic              act_set,
   input  logic              act_clr,
   input  logic              err_set,
   input  logic              irq_set,
   output logic [7:0]        ctl_byte,
   output logic [7:0]        flag_byte,
   output logic [PTR_W-1:0]  ptr,
   output logic              begin_p,
   output logic              halt_p
);
   logic run_q, dir_q, busy_q, fault_q, done_q, capa_q, capb_q;
   logic [PTR_W-1:PTR_ZERO] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         dir_q   <= 1'b0;
         begin_p <= 1'b0;
         halt_p  <= 1'b0;
      end else begin
         begin_p <= wr_ctl &  wbyte[C_RUN] & ~run_q;
         halt_p  <= wr_ctl & ~wbyte[C_RUN] &  run_q;
         if (wr_ctl) begin
            run_q <= wbyte[C_RUN];
            dir_q <= wbyte[C_DIR];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         fault_q <= 1'b0;
         done_q  <= 1'b0;
         capa_q  <= 1'b0;
         capb_q  <= 1'b0;
      end else begin
         busy_q  <= act_set | (busy_q & ~act_clr);
         fault_q <= err_set | (fault_q & ~(wr_flag & wbyte[F_FAULT]));
         done_q  <= irq_set | (done_q  & ~(wr_flag & wbyte[F_DONE]));
         if (wr_flag) begin
            capa_q <= wbyte[F_CAPA];
            capb_q <= wbyte[F_CAPB];
         end
      end
   end

   generate
      for (genvar b = 0; b < LANES; b++) begin : g_ptr_lane
         localparam int unsigned LO = (b == 0) ? PTR_ZERO : 8*b;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr_q[8*b+7:LO] <= '0;
            else if (wr_ptr && be[b])
               ptr_q[8*b+7:LO] <= wdata[8*b+7:LO];
         end
      end
   endgenerate

   always_comb begin
      ctl_byte        = '0;
      ctl_byte[C_RUN] = run_q;
      ctl_byte[C_DIR] = dir_q;
      flag_byte          = '0;
      flag_byte[F_BUSY]  = busy_q;
      flag_byte[F_FAULT] = fault_q;
      flag_byte[F_DONE]  = done_q;
      flag_byte[F_CAPA]  = capa_q;
      flag_byte[F_CAPB]  = capb_q;
   end

   assign ptr = {ptr_q, {PTR_ZERO{1'b0}}};
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   localparam int unsigned CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_req,
   input  logic [CIW-1:0]          chan_idx,
   input  logic                    chan_ok,
   input  logic                    is_ptr,
   input  logic                    single,
   input  logic [1:0]              lane,
   input  logic [LANES-1:0]        be,
   input  logic [8*NUM_CH-1:0]     ctl_all,
   input  logic [8*NUM_CH-1:0]     flag_all,
   input  logic [PTR_W*NUM_CH-1:0] ptr_all,
   output logic                    rd_valid,
   output logic [31:0]             rd_data
);
   logic [31:0] word, ctl_word;
   logic [7:0]  sel_byte;

   always_comb begin
      case (lane)
         LANE_CTL:  sel_byte = ctl_all[8*chan_idx +: 8];
         LANE_FLAG: sel_byte = flag_all[8*chan_idx +: 8];
         default:   sel_byte = 8'hFF;
      endcase
      if (single) begin
         ctl_word = '0;
         ctl_word[8*lane +: 8] = sel_byte;
      end else begin
         ctl_word = lane_mask(be);
      end
      if (!chan_ok)
         word = '0;
      else if (is_ptr)
         word = ptr_all[PTR_W*chan_idx +: PTR_W] & lane_mask(be);
      else
         word = ctl_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         rd_data  <= rd_req ? word : '0;
      end
   end
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
   import bmdma_pkg::*;
#(
   parameter int unsigned NUM_CH = 2,
   localparam int unsigned CIW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int unsigned AW  = (NUM_CH > 1) ? CIW + 1 : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_req,
   input  logic                    host_wr,
   input  logic [AW-1:0]           host_addr,
   input  logic [3:0]              host_be,
   input  logic [31:0]             host_wdata,
   output logic                    rd_valid,
   output logic [31:0]             rd_data,
   output logic [NUM_CH-1:0]       cmd_run,
   output logic [NUM_CH-1:0]       cmd_dir,
   output logic [NUM_CH-1:0]       start_pulse,
   output logic [NUM_CH-1:0]       stop_pulse,
   output logic [8*NUM_CH-1:0]     status_q,
   output logic [32*NUM_CH-1:0]    desc_ptr,
   input  logic [NUM_CH-1:0]       eng_act_set,
   input  logic [NUM_CH-1:0]       eng_act_clr,
   input  logic [NUM_CH-1:0]       eng_err_set,
   input  logic [NUM_CH-1:0]       eng_irq_set
);
   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("bmdma_regfile: NUM_CH must lie in 1..8");
      end
   endgenerate

   logic [CIW-1:0] chan_idx;
   logic           chan_ok, is_ptr, single;
   logic [1:0]     lane;
   logic [7:0]     wbyte;
   logic [8*NUM_CH-1:0] ctl_all;

   bmdma_decode #(.NUM_CH(NUM_CH)) u_dec (
      .addr     (host_addr),
      .be       (host_be),
      .wdata    (host_wdata),
      .chan_idx (chan_idx),
      .chan_ok  (chan_ok),
      .is_ptr   (is_ptr),
      .single   (single),
      .lane     (lane),
      .wbyte    (wbyte)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic hit, wr_ctl, wr_flag, wr_ptr;
         assign hit     = host_req & host_wr & chan_ok & (32'(chan_idx) == c);
         assign wr_ctl  = hit & ~is_ptr & single & (lane == LANE_CTL);
         assign wr_flag = hit & ~is_ptr & single & (lane == LANE_FLAG);
         assign wr_ptr  = hit & is_ptr;

         bmdma_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_ctl    (wr_ctl),
            .wr_flag   (wr_flag),
            .wr_ptr    (wr_ptr),
            .wbyte     (wbyte),
            .be        (host_be),
            .wdata     (host_wdata),
            .act_set   (eng_act_set[c]),
            .act_clr   (eng_act_clr[c]),
            .err_set   (eng_err_set[c]),
            .irq_set   (eng_irq_set[c]),
            .ctl_byte  (ctl_all[8*c +: 8]),
            .flag_byte (status_q[8*c +: 8]),
            .ptr       (desc_ptr[32*c +: 32]),
            .begin_p   (start_pulse[c]),
            .halt_p    (stop_pulse[c])
         );
         assign cmd_run[c] = ctl_all[8*c + C_RUN];
         assign cmd_dir[c] = ctl_all[8*c + C_DIR];
      end
   endgenerate

   bmdma_rdmux #(.NUM_CH(NUM_CH)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (host_req & ~host_wr),
      .chan_idx (chan_idx),
      .chan_ok  (chan_ok),
      .is_ptr   (is_ptr),
      .single   (single),
      .lane     (lane),
      .be       (host_be),
      .ctl_all  (ctl_all),
      .flag_all (status_q),
      .ptr_all  (desc_ptr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk #(
   parameter int unsigned NUM_CH = 2,
   parameter int unsigned AW = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 host_req,
   input logic                 host_wr,
   input logic [AW-1:0]        host_addr,
   input logic [3:0]           host_be,
   input logic                 rd_valid,
   input logic [31:0]          rd_data,
   input logic [NUM_CH-1:0]    cmd_run,
   input logic [NUM_CH-1:0]    cmd_dir,
   input logic [NUM_CH-1:0]    start_pulse,
   input logic [NUM_CH-1:0]    stop_pulse,
   input logic [8*NUM_CH-1:0]  status_q,
   input logic [NUM_CH-1:0]    eng_act_set,
   input logic [NUM_CH-1:0]    eng_act_clr,
   input logic [NUM_CH-1:0]    eng_err_set,
   input logic [NUM_CH-1:0]    eng_irq_set
);
   logic [NUM_CH-1:0] busy_v, fault_v, done_v, resv_v;
   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         busy_v[c]  = status_q[8*c + 0];
         fault_v[c] = status_q[8*c + 1];
         done_v[c]  = status_q[8*c + 2];
         resv_v[c]  = status_q[8*c + 3] | status_q[8*c + 4] | status_q[8*c + 7];
      end
   end

   // R8: begin and halt never coincide, and match the visible run bit
   assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse & stop_pulse) == '0);
   assert_begin_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_pulse & ~cmd_run) | (stop_pulse & cmd_run)) == '0);
   // R10: an answer only follows a read request
   assert_rd_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(host_req && !host_wr));
   assert_rd_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == 32'h0));
   // R6: without engine strobes busy holds
   assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_act_set == '0 && eng_act_clr == '0) |=> $stable(busy_v));
   // R7: set strobes land next cycle
   assert_fault_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_err_set != '0) |=> ((fault_v & $past(eng_err_set)) == $past(eng_err_set)));
   assert_done_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_irq_set != '0) |=> ((done_v & $past(eng_irq_set)) == $past(eng_irq_set)));
   // R4: wide control-dword write leaves control bits alone
   assert_wide_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_wr && !host_addr[0] && $countones(host_be) != 1)
      |=> ($stable(cmd_run) && $stable(cmd_dir)));
   // R5: unused flag bits stay zero
   assert_flag_resv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      resv_v == '0);
endmodule

bind bmdma_regfile bmdma_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_req    (host_req),
   .host_wr     (host_wr),
   .host_addr   (host_addr),
   .host_be     (host_be),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .cmd_run     (cmd_run),
   .cmd_dir     (cmd_dir),
   .start_pulse (start_pulse),
   .stop_pulse  (stop_pulse),
   .status_q    (status_q),
   .eng_act_set (eng_act_set),
   .eng_act_clr (eng_act_clr),
   .eng_err_set (eng_err_set),
   .eng_irq_set (eng_irq_set)
);

// File: tb/sim_bmdma_regfile.sv
`timescale 1ns/1ps
module sim_bmdma_regfile;
   localparam int NCH = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [3:0]  host_be = '0;
   logic [31:0] host_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [NCH-1:0] cmd_run, cmd_dir, start_pulse, stop_pulse;
   logic [8*NCH-1:0]  status_q;
   logic [32*NCH-1:0] desc_ptr;
   logic [NCH-1:0] eng_act_set = '0, eng_act_clr = '0, eng_err_set = '0, eng_irq_set = '0;

   always #2 clk = ~clk;

   bmdma_regfile #(.NUM_CH(NCH)) u0 (.*);

   // behavioural reference state
   bit [7:0]  m_ctl [NCH];
   bit [7:0]  m_flag[NCH];
   bit [31:0] m_ptr [NCH];
   bit        m_rv;
   bit [31:0] m_rd;
   bit [NCH-1:0] m_beg, m_halt;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   string cur_tag = "R1";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_ctl[c] = 0; m_flag[c] = 0; m_ptr[c] = 0;
         end
         m_rv = 0; m_rd = 0; m_beg = 0; m_halt = 0;
      end else begin
         int c, nl, ln;
         bit [7:0] b;
         m_rv = 0; m_rd = 0; m_beg = 0; m_halt = 0;
         c  = int'(host_addr[1]);
         nl = $countones(host_be);
         ln = 0;
         for (int k = 0; k < 4; k++) if (host_be[k]) ln = k;
         b = host_wdata[8*ln +: 8];
         if (host_req && !host_wr) begin
            m_rv = 1;
            for (int k = 0; k < 4; k++) begin
               bit [7:0] v;
               if (host_addr[0]) v = m_ptr[c][8*k +: 8];
               else if (nl != 1) v = 8'hFF;
               else if (k == 0) v = m_ctl[c];
               else if (k == 2) v = m_flag[c];
               else v = 8'hFF;
               if (host_be[k]) m_rd[8*k +: 8] = v;
            end
         end
         if (host_req && host_wr) begin
            if (host_addr[0]) begin
               for (int k = 0; k < 4; k++)
                  if (host_be[k]) m_ptr[c][8*k +: 8] = host_wdata[8*k +: 8];
               m_ptr[c][1:0] = 0;
            end else if (nl == 1 && ln == 0) begin
               if (b[0] && !m_ctl[c][0]) m_beg[c] = 1;
               if (!b[0] && m_ctl[c][0]) m_halt[c] = 1;
               m_ctl[c] = b & 8'h09;
            end else if (nl == 1 && ln == 2) begin
               m_flag[c] = (b & 8'h60) | (m_flag[c] & 8'h01) | (m_flag[c] & ~b & 8'h06);
            end
         end
         for (int k = 0; k < NCH; k++) begin
            if (eng_act_set[k]) m_flag[k][0] = 1;
            else if (eng_act_clr[k]) m_flag[k][0] = 0;
            if (eng_err_set[k]) m_flag[k][1] = 1;
            if (eng_irq_set[k]) m_flag[k][2] = 1;
         end
      end
   end

   task automatic cmp(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic [8*NCH-1:0]  ef;
      logic [32*NCH-1:0] ep;
      logic [NCH-1:0]    er, ed;
      cycles++;
      for (int c = 0; c < NCH; c++) begin
         ef[8*c +: 8] = m_flag[c];
         ep[32*c +: 32] = m_ptr[c];
         er[c] = m_ctl[c][0];
         ed[c] = m_ctl[c][3];
      end
      cmp("rd_valid", 64'(rd_valid), 64'(m_rv));
      cmp("rd_data",  64'(rd_data),  64'(m_rd));
      cmp("run",      64'(cmd_run),  64'(er));
      cmp("dir",      64'(cmd_dir),  64'(ed));
      cmp("begin",    64'(start_pulse), 64'(m_beg));
      cmp("halt",     64'(stop_pulse),  64'(m_halt));
      cmp("flags",    64'(status_q), 64'(ef));
      cmp("ptr",      64'(desc_ptr), 64'(ep));
   end

   task automatic acc(input bit w, input bit [1:0] a, input bit [3:0] be, input bit [31:0] d);
      host_req = 1; host_wr = w; host_addr = a; host_be = be; host_wdata = d;
      @(negedge clk);
      host_req = 0; host_wr = 0; host_be = 0; host_wdata = 0;
   endtask

   task automatic eng(input bit [NCH-1:0] s, input bit [NCH-1:0] c,
                      input bit [NCH-1:0] e, input bit [NCH-1:0] i);
      eng_act_set = s; eng_act_clr = c; eng_err_set = e; eng_irq_set = i;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle(1);
      cur_tag = "R1";
      for (int c = 0; c < 2; c++) begin acc(0, 2'(2*c), 4'b0001, 0); acc(0, 2'(2*c+1), 4'hF, 0); end
      idle(1);
      // R2: lane map of the control dword and the pointer dword
      cur_tag = "R2";
      for (int c = 0; c < 2; c++)
         for (int k = 0; k < 4; k++) begin
            acc(1, 2'(2*c), 4'(1 << k), 32'hFFFF_FFFF);
            acc(0, 2'(2*c), 4'(1 << k), 0);
         end
      acc(1, 2'b00, 4'b0001, 0); acc(1, 2'b10, 4'b0001, 0);
      // R3: wide reads of the control dword
      cur_tag = "R3";
      acc(1, 2'b00, 4'b0001, 32'h09);
      acc(0, 2'b00, 4'b0011, 0); acc(0, 2'b00, 4'b1100, 0); acc(0, 2'b00, 4'hF, 0);
      acc(0, 2'b00, 4'b0001, 0);
      // R4: wide writes of the control dword are dropped
      cur_tag = "R4";
      acc(1, 2'b00, 4'b0011, 32'h0000_0000); acc(1, 2'b00, 4'hF, 32'h0066_0000);
      acc(1, 2'b00, 4'b0000, 32'h0000_0008); acc(0, 2'b00, 4'b0100, 0);
      // R5: flag byte write rules
      cur_tag = "R5";
      eng(2'b01, 0, 2'b01, 2'b01); idle(1); eng(0, 0, 0, 0);
      acc(1, 2'b00, 4'b0100, 32'h00FF_0000); acc(0, 2'b00, 4'b0100, 0);
      eng(0, 0, 2'b01, 2'b01); idle(1); eng(0, 0, 0, 0);
      acc(1, 2'b00, 4'b0100, 32'h0002_0000); acc(1, 2'b00, 4'b0100, 32'h0004_0000);
      acc(1, 2'b00, 4'b0100, 32'h0020_0000);
      // R6: busy is engine owned
      cur_tag = "R6";
      eng(2'b11, 2'b11, 0, 0); idle(1); eng(0, 0, 0, 0);
      acc(1, 2'b10, 4'b0100, 32'h0001_0000);
      eng(0, 2'b01, 0, 0); idle(1); eng(0, 0, 0, 0);
      acc(1, 2'b00, 4'b0100, 32'h0001_0000);
      // R7: set strobe beats host clear in the same cycle
      cur_tag = "R7";
      eng(0, 0, 2'b01, 2'b10);
      host_req = 1; host_wr = 1; host_addr = 2'b00; host_be = 4'b0100; host_wdata = 32'h0006_0000;
      @(negedge clk);
      host_req = 0; host_wr = 0; host_be = 0; eng(0, 0, 0, 0);
      acc(1, 2'b10, 4'b0100, 32'h0006_0000);
      // R8: run toggles
      cur_tag = "R8";
      acc(1, 2'b00, 4'b0001, 32'hFE); acc(1, 2'b00, 4'b0001, 32'h01);
      acc(1, 2'b00, 4'b0001, 32'h01); acc(1, 2'b00, 4'b0001, 32'h08);
      acc(1, 2'b00, 4'b0001, 32'h00); idle(1);
      // R9: pointer per-byte writes
      cur_tag = "R9";
      acc(1, 2'b01, 4'hF, 32'hDEAD_BEEF); acc(1, 2'b01, 4'b0010, 32'h0000_5500);
      acc(1, 2'b01, 4'b1000, 32'h1200_0000); acc(0, 2'b01, 4'b0101, 0);
      acc(1, 2'b11, 4'b0001, 32'h0000_0003); acc(0, 2'b11, 4'hF, 0);
      // R10: back-to-back reads and read after write
      cur_tag = "R10";
      acc(0, 2'b01, 4'hF, 0); acc(0, 2'b11, 4'hF, 0);
      acc(1, 2'b01, 4'hF, 32'h0BAD_F00C); acc(0, 2'b01, 4'hF, 0); idle(2);
      // R11: channel isolation, then mixed traffic
      cur_tag = "R11";
      acc(1, 2'b10, 4'b0001, 32'h09); acc(1, 2'b00, 4'b0001, 32'h00);
      for (int n = 0; n < 4000; n++) begin
         bit [3:0] be;
         case ($urandom_range(0, 6))
            0: be = 4'b0001; 1: be = 4'b0010; 2: be = 4'b0100; 3: be = 4'b1000;
            4: be = 4'b0011; 5: be = 4'b1100; default: be = 4'hF;
         endcase
         eng(2'($urandom_range(0,3) & $urandom_range(0,3)), 2'($urandom_range(0,3)),
             2'($urandom_range(0,3) & $urandom_range(0,3)), 2'($urandom_range(0,3) & $urandom_range(0,3)));
         if ($urandom_range(0, 3) != 0) acc(1'($urandom_range(0,1)), 2'($urandom_range(0,3)), be, $urandom);
         else idle(1);
      end
      eng(0, 0, 0, 0); idle(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule